// File: doc/BRIEF.md
# Split-Carry Approximate Adder

This combinational adder trades accuracy for a shorter carry path in arithmetic that tolerates errors, such as signal or image filtering. Each operand is divided into two fields. The upper field is summed exactly by a ripple-carry chain whose carry-in is zero. Each result bit of the lower field is the NAND of the two operand bits at that position. No carry leaves the lower field, so the critical path covers only the upper field.

Two parameters set the total width and the width of the approximate field. The required configurations are 8 bits with a 4-bit approximate field and 16 bits with a 4-bit approximate field. With an approximate field of width zero, the block is an exact ripple-carry adder. The carry out of the top bit of the exact field appears on its own output.

Top module: `split_approx_adder`

## Requirements
- R1: For every bit position i below LOW_W, result bit i is 0 when both operand bits i are 1, and 1 otherwise.
- R2: Result bits WIDTH-1 down to LOW_W are the exact sum, modulo 2^(WIDTH-LOW_W), of the operand fields WIDTH-1 down to LOW_W, added with a carry-in of zero.
- R3: The carry output is 1 exactly when the sum of the two upper fields reaches 2^(WIDTH-LOW_W).
- R4: With WIDTH=8 and LOW_W=4, operands 0x6D and 0x6C give result 0xC3 with carry 0, although the exact sum is 0xD9.
- R5: With WIDTH=16 and LOW_W=4, the upper twelve bits and the carry follow R2 and R3, and the lower four bits follow R1.
- R6: With LOW_W=0, the carry output followed by the result equals the full exact sum of the operands.
- R7: Changing only the lower LOW_W bits of either operand leaves the upper result bits and the carry output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| sum_o | output | WIDTH | Result: exact upper field over approximate lower field |
| carry_o | output | 1 | Carry out of the top bit of the exact field |

## Verification
Whenever the operands change, the assertions check the per-bit NAND rule for the lower field, the exact sum of the upper field together with its carry, the wrap relation between the carry and the upper result, and, in the exact configuration, equality with the full sum. The lower-to-upper isolation and the fixed example pattern can only be shown by the bench. It drives two instances whose upper fields agree and whose lower fields differ, and it applies the specific operand pair. The bench also reports how often the approximate result happens to equal the exact sum.

// File: rtl/split_adder_pkg.sv
// Shared types for the split-carry approximate adder.
// Assumes nothing beyond standard two-state bit arithmetic.
package split_adder_pkg;

    // Result of a one-bit addition cell
    typedef struct packed {
        logic carry;
        logic sum;
    } bit_add_t;

    // Width of the exact field for a given split
    function automatic int exact_width(input int total_w, input int approx_w);
        return total_w - approx_w;
    endfunction

endpackage

// File: rtl/sa_full_add.sv
// One-bit full adder cell.
// Assumes single-bit operands; purely combinational.
module sa_full_add
    import split_adder_pkg::*;
(
    input  logic     x_i,
    input  logic     y_i,
    input  logic     cin_i,
    output bit_add_t res_o
);

    // Sum and majority carry of three equal-weight bits
    always_comb begin
        res_o.sum   = x_i ^ y_i ^ cin_i;
        res_o.carry = (x_i & y_i) | ((x_i ^ y_i) & cin_i);
    end

endmodule

// File: rtl/sa_ripple_chain.sv
// Exact ripple-carry adder of EXACT_W bits, carry-in tied to zero.
// Assumes EXACT_W >= 1. Carry travels from bit 0 upward.
module sa_ripple_chain
    import split_adder_pkg::*;
#(
    parameter int EXACT_W = 4
) (
    input  logic [EXACT_W-1:0] x_i,
    input  logic [EXACT_W-1:0] y_i,
    output logic [EXACT_W-1:0] sum_o,
    output logic               cout_o
);

    logic     [EXACT_W:0]   carry_w;
    bit_add_t [EXACT_W-1:0] cell_w;

    assign carry_w[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < EXACT_W; gi++) begin : g_cell
            sa_full_add u_fa (
                .x_i   (x_i[gi]),
                .y_i   (y_i[gi]),
                .cin_i (carry_w[gi]),
                .res_o (cell_w[gi])
            );
            assign sum_o[gi]     = cell_w[gi].sum;
            assign carry_w[gi+1] = cell_w[gi].carry;
        end
    endgenerate

    assign cout_o = carry_w[EXACT_W];

endmodule

// File: rtl/sa_nand_field.sv
// Approximate lower field: each result bit is the NAND of its operand bits.
// Assumes APPROX_W >= 1. Produces no carry.
module sa_nand_field #(
    parameter int APPROX_W = 4
) (
    input  logic [APPROX_W-1:0] x_i,
    input  logic [APPROX_W-1:0] y_i,
    output logic [APPROX_W-1:0] res_o
);

    genvar gi;
    generate
        for (gi = 0; gi < APPROX_W; gi++) begin : g_bit
            // Independent per-bit approximation
            assign res_o[gi] = ~(x_i[gi] & y_i[gi]);
        end
    endgenerate

endmodule

// File: rtl/split_approx_adder.sv
// Split-carry approximate adder, top level.
// Upper WIDTH-LOW_W bits: exact ripple sum, carry-in zero.
// Lower LOW_W bits: per-bit NAND, no carry into the upper field.
// Assumes 0 <= LOW_W < WIDTH. Purely combinational, no clock or reset.
module split_approx_adder
    import split_adder_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int LOW_W = 4
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o
);

    localparam int UP_W = exact_width(WIDTH, LOW_W);

    sa_ripple_chain #(.EXACT_W(UP_W)) u_exact (
        .x_i    (opnd_a[WIDTH-1:LOW_W]),
        .y_i    (opnd_b[WIDTH-1:LOW_W]),
        .sum_o  (sum_o[WIDTH-1:LOW_W]),
        .cout_o (carry_o)
    );

    generate
        if (LOW_W > 0) begin : g_approx
            sa_nand_field #(.APPROX_W(LOW_W)) u_approx (
                .x_i   (opnd_a[LOW_W-1:0]),
                .y_i   (opnd_b[LOW_W-1:0]),
                .res_o (sum_o[LOW_W-1:0])
            );
        end
    endgenerate

endmodule

// File: rtl/split_approx_adder_chk.sv
// Checker for split_approx_adder, attached by bind.
// Assumes inputs settle before the checker process runs.
module split_approx_adder_chk #(
    parameter int WIDTH = 8,
    parameter int LOW_W = 4
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [WIDTH-1:0] sum_o,
    input logic             carry_o
);

    localparam int UP_W = WIDTH - LOW_W;

    logic [UP_W-1:0] a_up, b_up, s_up;
    logic [UP_W:0]   up_ref;

    // Reference upper-field sum and bit-level checks
    always_comb begin
        a_up   = opnd_a[WIDTH-1:LOW_W];
        b_up   = opnd_b[WIDTH-1:LOW_W];
        s_up   = sum_o[WIDTH-1:LOW_W];
        up_ref = {1'b0, a_up} + {1'b0, b_up};
        for (int i = 0; i < LOW_W; i++) begin
            // R1
            lower_nand_chk: assert (sum_o[i] == !(opnd_a[i] && opnd_b[i]));
        end
        // R2
        upper_exact_chk: assert (s_up == up_ref[UP_W-1:0]);
        // R3
        carry_wrap_chk: assert (carry_o == (s_up < a_up));
    end

    generate
        if (LOW_W == 0) begin : g_exact
            logic [WIDTH:0] full_ref;
            // Full-sum equality in the exact configuration
            always_comb begin
                full_ref = {1'b0, opnd_a} + {1'b0, opnd_b};
                // R6
                exact_mode_chk: assert ({carry_o, sum_o} == full_ref);
            end
        end
    endgenerate

endmodule

bind split_approx_adder split_approx_adder_chk #(.WIDTH(WIDTH), .LOW_W(LOW_W)) u_chk (
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .sum_o   (sum_o),
    .carry_o (carry_o)
);

// File: tb/tb_split_approx_adder.sv
// Bench: exhaustive 8/4 and 8/0 sweeps, random 16/4 with lower-field perturbation.
module tb_split_approx_adder;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int n_match = 0;
    bit done = 1'b0;

    logic [7:0]  a8, b8, s8, s8x;
    logic        c8, c8x;
    logic [15:0] a16, b16, a16p, b16p, s16, s16p;
    logic        c16, c16p;

    split_approx_adder #(.WIDTH(8), .LOW_W(4)) dut (
        .opnd_a(a8), .opnd_b(b8), .sum_o(s8), .carry_o(c8));
    split_approx_adder #(.WIDTH(8), .LOW_W(0)) dut_exact (
        .opnd_a(a8), .opnd_b(b8), .sum_o(s8x), .carry_o(c8x));
    split_approx_adder #(.WIDTH(16), .LOW_W(4)) dut_wide (
        .opnd_a(a16), .opnd_b(b16), .sum_o(s16), .carry_o(c16));
    split_approx_adder #(.WIDTH(16), .LOW_W(4)) dut_wide_p (
        .opnd_a(a16p), .opnd_b(b16p), .sum_o(s16p), .carry_o(c16p));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nand_low(input logic [31:0] x, input logic [31:0] y, input int lw);
        return (~(x & y)) & ((32'd1 << lw) - 32'd1);
    endfunction

    initial begin
        logic [31:0] up, exp_full;
        a8 = '0; b8 = '0; a16 = '0; b16 = '0; a16p = '0; b16p = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Zero operands: lower field all ones, no carry (R1, R3)
        @(negedge clk);
        check("R1 zero", {24'd0, s8}, 32'h0F);
        check("R3 zero", {31'd0, c8}, 32'd0);

        // Fixed example (R4)
        @(posedge clk); a8 = 8'h6D; b8 = 8'h6C;
        @(negedge clk);
        check("R4 sum", {24'd0, s8}, 32'hC3);
        check("R4 carry", {31'd0, c8}, 32'd0);

        // Exhaustive 8-bit sweep: approximate (R1 R2 R3) and exact (R6)
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                @(posedge clk); a8 = 8'(ia); b8 = 8'(ib);
                @(negedge clk);
                up = (32'(ia) >> 4) + (32'(ib) >> 4);
                exp_full = 32'(ia) + 32'(ib);
                check("R1", {28'd0, s8[3:0]}, nand_low(32'(ia), 32'(ib), 4));
                check("R2", {28'd0, s8[7:4]}, up & 32'hF);
                check("R3", {31'd0, c8}, (up >> 4) & 32'd1);
                check("R6", {23'd0, c8x, s8x}, exp_full);
                if ({23'd0, c8, s8} == exp_full) n_match++;
            end
        end
        $display("8/4 exact-match fraction: %0d / 65536 = %f", n_match, real'(n_match) / 65536.0);

        // Random 16-bit with perturbed lower fields (R5, R7)
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] ra, rb;
            ra = $urandom & 32'hFFFF;
            rb = $urandom & 32'hFFFF;
            @(posedge clk);
            a16 = ra[15:0]; b16 = rb[15:0];
            a16p = {ra[15:4], ~ra[3:0]};
            b16p = {rb[15:4], 4'(ra[3:0] + 4'(k))};
            @(negedge clk);
            up = (ra >> 4) + (rb >> 4);
            check("R5 low", {28'd0, s16[3:0]}, nand_low(ra, rb, 4));
            check("R5 up", {20'd0, s16[15:4]}, up & 32'hFFF);
            check("R5 carry", {31'd0, c16}, (up >> 12) & 32'd1);
            check("R7 up", {20'd0, s16p[15:4]}, {20'd0, s16[15:4]});
            check("R7 carry", {31'd0, c16p}, {31'd0, c16});
        end

        // Lower-field change on the 8-bit unit (R7)
        @(posedge clk); a8 = 8'hF0; b8 = 8'hF0;
        @(negedge clk);
        check("R7 base", {24'd0, s8}, 32'hEF);
        @(posedge clk); a8 = 8'hFF; b8 = 8'hFF;
        @(negedge clk);
        check("R7 upper", {28'd0, s8[7:4]}, 32'hE);
        check("R7 carry8", {31'd0, c8}, 32'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule